// File: doc/BRIEF.md
# Byte-Handshake I2C Master

This block is an I2C bus master driven one byte at a time by a processor through a small register file. The processor writes a command word, which holds the slave address, the direction and the speed. The master then issues a START and shifts out the address byte. After every byte, including the address byte, it raises a byte-end interrupt and parks with SCL pulled low. It moves on only when the processor sets a ready bit.

Together with ready, the processor chooses what happens next. It can ask for another data byte, a STOP, or a repeated START to a new command that was written while the bus was parked. For reads, a control bit makes the master answer the next received byte with NACK. If the slave does not acknowledge its address, the master raises an interrupt, sends STOP on its own and goes idle. A released SCL that another device holds low longer than a programmed count raises a timeout interrupt and aborts the transfer.

Register offsets on `reg_addr`:
- 0: control
- 1: command
- 2: data
- 3: status (read only)
- 4: interrupt status
- 5: interrupt mask
- 6: timing

Reads are combinational. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `hsi2c_master`

## Requirements
- R1: After reset, both line pulls are off, `irq` is low, and the control, status and interrupt status registers read 0.
- R2: The command register holds the slave address in bits [6:0], the direction in bit 7 (1 = read) and fast mode in bit 8. When a command has been written and control bit 0 (enable) is 1, the master issues START and sends {address, direction} MSB first.
- R3: After each byte, interrupt status bit 1 (byte end) is set and SCL stays pulled low until control bit 1 (ready) is 1. Ready clears itself when the master acts on it.
- R4: In a write, each ready without STOP sends the byte held in data register bits [7:0].
- R5: In a read, each received byte appears in data register bits [15:8]. The master ACKs it unless control bit 2 (next-NACK) was 1 when the byte began, in which case it NACKs.
- R6: Ready together with control bit 3 (stop) sends STOP, after which status bit 0 (busy) reads 0.
- R7: A command written while the bus is parked, followed by ready without stop, makes the master send a repeated START with no STOP in between, and then the new address byte.
- R8: If the address byte is not acknowledged, interrupt status bit 0 is set and the master sends STOP and goes idle without waiting for ready.
- R9: Status bit 1 holds the ACK level of the last byte the master sent (1 = NACK). A NACKed data byte still raises byte end.
- R10: Ready with stop straight after the address byte completes a write with no data byte.
- R11: Each interrupt status bit is cleared only by writing 1 to it. `irq` is the OR of interrupt status AND the mask register, whose bit layout is the same.
- R12: Timing bits [7:0] give the SCL half period H in clock cycles. In fast mode the half period is H/4, with a minimum of 1. The high phase of every data bit lasts exactly one half period.
- R13: If SCL stays low for more than timing bits [15:8] cycles while the master has released it, interrupt status bit 2 is set, the transfer is aborted, the master goes idle and both pulls turn off.
- R14: With enable at 0, both pulls turn off and the master is idle from the next cycle on. A command written while enable is 0 starts only once enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Masked interrupt request |
| scl_in | input | 1 | Sampled SCL level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Sampled SDA level |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach from the ports is SCL held low by some other device while the master waits for it to rise. The bench adds a second open-drain pull on SCL and switches it on just before it releases a parked byte, so the master's high phase never starts and the stuck counter runs out.

The repeated START is the other hard case, because it needs a command to arrive while the bus is parked. The bench writes a read command between two byte-end interrupts of a write. A behavioural slave on the wires counts STARTs and STOPs and records every byte and acknowledge it sees.

// File: rtl/hsi2c_pkg.sv
package hsi2c_pkg;
    localparam int REG_W = 16;

    // register offsets
    localparam logic [2:0] OFF_CTRL = 3'd0;
    localparam logic [2:0] OFF_CMD  = 3'd1;
    localparam logic [2:0] OFF_DATA = 3'd2;
    localparam logic [2:0] OFF_STAT = 3'd3;
    localparam logic [2:0] OFF_ISR  = 3'd4;
    localparam logic [2:0] OFF_MASK = 3'd5;
    localparam logic [2:0] OFF_TIM  = 3'd6;

    // interrupt source bit positions
    localparam int IB_ANACK = 0;
    localparam int IB_BEND  = 1;
    localparam int IB_STUCK = 2;
    localparam int N_IRQ    = 3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_HOLD,
        ST_RS_A, ST_RS_B, ST_STP_A, ST_STP_B, ST_STP_C
    } bus_st_e;
endpackage

// File: rtl/hsi2c_phase_timer.sv
module hsi2c_phase_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] limit,
    input  logic          stuck,
    input  logic [CW-1:0] tmo,
    output logic          done,
    output logic          expired
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] scnt;
    } tmr_s;

    tmr_s d, q;

    always_comb begin
        d = q;
        if (clr)      d.cnt = '0;
        else if (run) d.cnt = q.cnt + 1'b1;
        if (!stuck)                d.scnt = '0;
        else if (!(&q.scnt))       d.scnt = q.scnt + 1'b1;
    end

    assign done    = run && (q.cnt == limit - 1'b1);
    assign expired = stuck && (q.scnt > tmo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/hsi2c_master.sv
module hsi2c_master
    import hsi2c_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int TMO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    input  logic             scl_in,
    output logic             scl_pull,
    input  logic             sda_in,
    output logic             sda_pull
);
    localparam int TIM_W = HALF_W + TMO_W;
    localparam int CNT_W = ((HALF_W > TMO_W) ? HALF_W : TMO_W) + 1;

    typedef struct packed {
        bus_st_e          st;
        logic             en, rdy, nnack, stp;
        logic [8:0]       cmd;
        logic             pend, dir, fast;
        logic [7:0]       wdat, rdat, sh;
        logic [3:0]       bitn;
        logic             addr_ph, rx, nack_now, ackl;
        logic [N_IRQ-1:0] isr, imr;
        logic [TIM_W-1:0] tim;
    } core_s;

    core_s d, q;
    logic tmr_clr, tmr_run, stuck, tmr_done, tmr_exp;
    logic scl_p, sda_p, drv_bit;
    logic [HALF_W-1:0] half_eff;
    logic [CNT_W-1:0]  lim_w, tmo_w;

    always_comb begin
        half_eff = q.fast ? (q.tim[HALF_W-1:0] >> 2) : q.tim[HALF_W-1:0];
        if (half_eff == '0) half_eff = {{(HALF_W-1){1'b0}}, 1'b1};
        lim_w = CNT_W'(half_eff);
        tmo_w = CNT_W'(q.tim[TIM_W-1:HALF_W]);
    end

    hsi2c_phase_timer #(.CW(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .limit(lim_w),
        .stuck(stuck), .tmo(tmo_w), .done(tmr_done), .expired(tmr_exp)
    );

    // bit driven on SDA for the current slot: data bits when sending, ACK when receiving
    assign drv_bit = (q.bitn == 4'd8) ? (q.rx && !q.nack_now) : (!q.rx && !q.sh[7]);

    always_comb begin
        d = q;
        tmr_run = 1'b0;
        stuck   = 1'b0;
        scl_p   = 1'b0;
        sda_p   = 1'b0;

        // register writes (FSM events below take priority)
        if (reg_wr) begin
            case (reg_addr)
                OFF_CTRL: {d.stp, d.nnack, d.rdy, d.en} = reg_wdata[3:0];
                OFF_CMD:  begin d.cmd = reg_wdata[8:0]; d.pend = 1'b1; end
                OFF_DATA: d.wdat = reg_wdata[7:0];
                OFF_ISR:  d.isr = q.isr & ~reg_wdata[N_IRQ-1:0];
                OFF_MASK: d.imr = reg_wdata[N_IRQ-1:0];
                OFF_TIM:  d.tim = reg_wdata[TIM_W-1:0];
                default:  ;
            endcase
        end

        case (q.st)
            ST_IDLE: if (q.en && q.pend) begin
                d.pend = 1'b0; d.rdy = 1'b0;
                d.dir = q.cmd[7]; d.fast = q.cmd[8];
                d.st = ST_START;
            end
            ST_START: begin
                sda_p = 1'b1; tmr_run = 1'b1;
                if (tmr_done) begin
                    d.sh = {q.cmd[6:0], q.dir};
                    d.rx = 1'b0; d.addr_ph = 1'b1; d.bitn = '0;
                    d.st = ST_LOW;
                end
            end
            ST_LOW: begin
                scl_p = 1'b1; sda_p = drv_bit; tmr_run = 1'b1;
                if (tmr_done) d.st = ST_HIGH;
            end
            ST_HIGH: begin
                sda_p = drv_bit;
                if (scl_in) tmr_run = 1'b1; else stuck = 1'b1;
                if (tmr_exp) begin
                    d.isr[IB_STUCK] = 1'b1; d.st = ST_IDLE;
                end else if (tmr_done) begin
                    if (q.bitn != 4'd8) begin
                        d.sh   = {q.sh[6:0], q.rx ? sda_in : 1'b0};
                        d.bitn = q.bitn + 4'd1;
                        d.st   = ST_LOW;
                    end else begin
                        if (!q.rx) d.ackl = sda_in;
                        else       d.rdat = q.sh;
                        d.addr_ph = 1'b0;
                        if (q.addr_ph && sda_in) begin
                            d.isr[IB_ANACK] = 1'b1; d.st = ST_STP_A;
                        end else begin
                            d.isr[IB_BEND] = 1'b1; d.st = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                scl_p = 1'b1;
                if (q.rdy) begin
                    d.rdy = 1'b0;
                    if (q.stp) d.st = ST_STP_A;
                    else if (q.pend) begin
                        d.pend = 1'b0; d.dir = q.cmd[7]; d.fast = q.cmd[8];
                        d.st = ST_RS_A;
                    end else begin
                        d.bitn = '0; d.rx = q.dir; d.nack_now = q.nnack;
                        d.sh = q.wdat; d.st = ST_LOW;
                    end
                end
            end
            ST_RS_A: begin
                scl_p = 1'b1; tmr_run = 1'b1;
                if (tmr_done) d.st = ST_RS_B;
            end
            ST_RS_B: begin
                if (scl_in) tmr_run = 1'b1; else stuck = 1'b1;
                if (tmr_exp) begin d.isr[IB_STUCK] = 1'b1; d.st = ST_IDLE; end
                else if (tmr_done) d.st = ST_START;
            end
            ST_STP_A: begin
                scl_p = 1'b1; sda_p = 1'b1; tmr_run = 1'b1;
                if (tmr_done) d.st = ST_STP_B;
            end
            ST_STP_B: begin
                sda_p = 1'b1;
                if (scl_in) tmr_run = 1'b1; else stuck = 1'b1;
                if (tmr_exp) begin d.isr[IB_STUCK] = 1'b1; d.st = ST_IDLE; end
                else if (tmr_done) d.st = ST_STP_C;
            end
            ST_STP_C: begin
                tmr_run = 1'b1;
                if (tmr_done) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (!q.en) d.st = ST_IDLE;
        tmr_clr = (d.st != q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign scl_pull = q.en && scl_p;
    assign sda_pull = q.en && sda_p;
    assign irq      = |(q.isr & q.imr);

    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = {12'd0, q.stp, q.nnack, q.rdy, q.en};
            OFF_CMD:  reg_rdata = {7'd0, q.cmd};
            OFF_DATA: reg_rdata = {q.rdat, q.wdat};
            OFF_STAT: reg_rdata = {13'd0, (q.st == ST_HOLD), q.ackl, (q.st != ST_IDLE)};
            OFF_ISR:  reg_rdata = REG_W'(q.isr);
            OFF_MASK: reg_rdata = REG_W'(q.imr);
            OFF_TIM:  reg_rdata = REG_W'(q.tim);
            default:  reg_rdata = '0;
        endcase
    end

    // ---------------- assertions ----------------
    assert_hold_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.isr[IB_BEND]) && q.en) |-> scl_pull);

    assert_addr_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.isr[IB_ANACK]) && q.en) |-> (scl_pull && sda_pull));

    assert_timeout_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.isr[IB_STUCK]) |-> (!scl_pull && !sda_pull));

    assert_disable_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |=> (reg_rdata[0] == 1'b0 || reg_addr != OFF_STAT) && !scl_pull && !sda_pull);

    for (genvar k = 0; k < N_IRQ; k++) begin : g_w1c
        assert_w1c_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(q.isr[k]) |-> $past(reg_wr && reg_addr == OFF_ISR && reg_wdata[k]));
    end
endmodule

// File: tb/hsi2c_master_tb.sv
module hsi2c_master_tb;
    localparam logic [2:0] A_CTRL = 3'd0, A_CMD = 3'd1, A_DATA = 3'd2, A_STAT = 3'd3,
                           A_ISR = 3'd4, A_MASK = 3'd5, A_TIM = 3'd6;
    localparam logic [15:0] EN = 16'h1, RDY = 16'h2, NN = 16'h4, STP = 16'h8;
    localparam logic [6:0] SLV = 7'h5A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic irq, scl_pull, sda_pull, scl_in, sda_in;
    logic force_scl = 1'b0, slv_sda_low;

    always #2.5 clk = ~clk;

    assign scl_in = !(scl_pull || force_scl);
    assign sda_in = !(sda_pull || slv_sda_low);

    hsi2c_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_in(scl_in), .scl_pull(scl_pull), .sda_in(sda_in), .sda_pull(sda_pull)
    );

    int n_chk = 0, n_fail = 0;

    // ---------------- behavioural slave and bus monitor ----------------
    int starts, stops, bitn, hi_w, min_hi;
    bit sp, spd, active, first, txmode, rd, ack, got8, mack, nack_data, from_low;
    logic [7:0] sh, cur, last_addr;
    logic [7:0] rxq[$], txq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            starts = 0; stops = 0; bitn = 0; active = 0; txmode = 0; got8 = 0;
            sp = 1; spd = 1; slv_sda_low <= 1'b0; hi_w = 0; from_low = 0; min_hi = 1000;
        end else begin
            if (scl_in) hi_w++;
            else begin
                if (hi_w > 0 && from_low && hi_w < min_hi) min_hi = hi_w;
                hi_w = 0; from_low = 1;
            end
            if (sp && scl_in && spd && !sda_in) begin
                starts++; bitn = -1; first = 1; txmode = 0; active = 1; got8 = 0;
                slv_sda_low <= 1'b0;
            end else if (sp && scl_in && !spd && sda_in) begin
                stops++; active = 0; txmode = 0; slv_sda_low <= 1'b0;
            end else if (!sp && scl_in && active) begin
                if (bitn >= 0 && bitn < 8) sh = {sh[6:0], sda_in};
                else if (bitn == 8) mack = !sda_in;
            end else if (sp && !scl_in && active) begin
                bitn++;
                if (bitn == 9) bitn = 0;
                if (bitn == 8) begin
                    got8 = 1;
                    if (txmode) slv_sda_low <= 1'b0;
                    else if (first) begin
                        last_addr = sh; ack = (sh[7:1] == SLV); rd = sh[0];
                        slv_sda_low <= ack;
                    end else begin
                        rxq.push_back(sh); slv_sda_low <= !nack_data;
                    end
                end else if (bitn == 0) begin
                    slv_sda_low <= 1'b0;
                    if (got8) begin
                        if (first) begin first = 0; txmode = ack && rd; active = ack; end
                        else if (txmode) txmode = mack;
                        if (txmode) begin
                            cur = (txq.size() > 0) ? txq.pop_front() : 8'hFF;
                            slv_sda_low <= !cur[7];
                        end
                    end
                    got8 = 0;
                end else if (txmode) begin
                    slv_sda_low <= !cur[7-bitn];
                end
            end
            sp = scl_in; spd = sda_in;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rdr(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        chk(req, irq, 1'b1);
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] v;
        int n = 0;
        rdr(A_STAT, v);
        while (v[0] && n < 5000) begin rdr(A_STAT, v); n++; end
        chk(req, v[0], 1'b0);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] v;
        int s0, t0, n0;
        nack_data = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdr(A_STAT, v); chk("R1 status", v, 16'h0);
        rdr(A_ISR, v);  chk("R1 isr", v, 16'h0);
        rdr(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
        chk("R1 lines", {irq, scl_pull, sda_pull}, 3'b000);

        wr(A_TIM, {8'd40, 8'd8});
        wr(A_MASK, 16'h7);
        wr(A_CTRL, EN);

        // two-byte write with STOP
        min_hi = 1000;
        wr(A_CMD, {9'h0, SLV});
        wait_irq("R3 addr byte end");
        rdr(A_ISR, v);  chk("R3 isr byte end", v, 16'h2);
        rdr(A_STAT, v); chk("R9 addr ack level", v[1], 1'b0);
        chk("R2 start seen", starts, 1);
        chk("R2 address byte", last_addr, {SLV, 1'b0});
        repeat (40) @(negedge clk);
        chk("R3 scl held", scl_pull, 1'b1);
        wr(A_ISR, 16'h7);
        chk("R11 irq cleared", irq, 1'b0);
        wr(A_DATA, 16'h00A5); wr(A_CTRL, EN | RDY);
        wait_irq("R4 byte 1");
        rdr(A_CTRL, v); chk("R3 ready self-clears", v[1], 1'b0);
        wr(A_ISR, 16'h7);
        wr(A_DATA, 16'h003C); wr(A_CTRL, EN | RDY);
        wait_irq("R4 byte 2");
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | STP);
        wait_idle("R6 idle after stop");
        chk("R6 stop seen", stops, 1);
        chk("R4 count", rxq.size(), 2);
        if (rxq.size() == 2) begin
            chk("R4 first data", rxq[0], 8'hA5);
            chk("R4 second data", rxq[1], 8'h3C);
        end
        chk("R12 standard high phase", min_hi, 8);
        chk("R6 lines released", {scl_pull, sda_pull}, 2'b00);

        // two-byte read
        txq.push_back(8'hC3); txq.push_back(8'h7E);
        wr(A_CMD, {9'h1, SLV});
        wait_irq("R5 read addr");
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY);
        wait_irq("R5 read byte 1");
        rdr(A_DATA, v); chk("R5 rx byte 1", v[15:8], 8'hC3);
        chk("R5 master ack", mack, 1'b1);
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | NN);
        wait_irq("R5 read byte 2");
        rdr(A_DATA, v); chk("R5 rx byte 2", v[15:8], 8'h7E);
        chk("R5 master nack", mack, 1'b0);
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | STP);
        wait_idle("R6 read idle");
        chk("R6 read stop", stops, 2);

        // address NACK
        wr(A_CMD, 16'h0011);
        wait_irq("R8 nack irq");
        rdr(A_ISR, v); chk("R8 isr addr nack", v, 16'h1);
        wait_idle("R8 auto idle");
        chk("R8 auto stop", stops, 3);
        rdr(A_STAT, v); chk("R9 addr nack level", v[1], 1'b1);
        wr(A_MASK, 16'h6);
        chk("R11 masked irq", irq, 1'b0);
        wr(A_ISR, 16'h2);
        rdr(A_ISR, v); chk("R11 other bit kept", v, 16'h1);
        wr(A_ISR, 16'h1);
        rdr(A_ISR, v); chk("R11 bit cleared", v, 16'h0);
        wr(A_MASK, 16'h7);

        // data NACK
        nack_data = 1;
        wr(A_CMD, {9'h0, SLV});
        wait_irq("R9 addr");
        wr(A_ISR, 16'h7);
        wr(A_DATA, 16'h0099); wr(A_CTRL, EN | RDY);
        wait_irq("R9 data byte end");
        rdr(A_ISR, v);  chk("R9 byte end on nack", v, 16'h2);
        rdr(A_STAT, v); chk("R9 nack level", v[1], 1'b1);
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | STP);
        wait_idle("R9 idle");
        nack_data = 0;

        // zero-length write
        n0 = rxq.size(); s0 = starts; t0 = stops;
        wr(A_CMD, {9'h0, SLV});
        wait_irq("R10 addr");
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | STP);
        wait_idle("R10 idle");
        chk("R10 no data byte", rxq.size(), n0);
        chk("R10 start", starts, s0 + 1);
        chk("R10 stop", stops, t0 + 1);

        // repeated START: write one byte, then read one byte
        s0 = starts; t0 = stops;
        txq.push_back(8'h5E);
        wr(A_CMD, {9'h0, SLV});
        wait_irq("R7 addr");
        wr(A_ISR, 16'h7);
        wr(A_DATA, 16'h0010); wr(A_CTRL, EN | RDY);
        wait_irq("R7 data");
        wr(A_ISR, 16'h7);
        wr(A_CMD, {9'h1, SLV});
        wr(A_CTRL, EN | RDY);
        wait_irq("R7 read addr");
        chk("R7 two starts", starts, s0 + 2);
        chk("R7 no stop between", stops, t0);
        chk("R7 new address", last_addr, {SLV, 1'b1});
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | NN);
        wait_irq("R7 read byte");
        rdr(A_DATA, v); chk("R7 rx after restart", v[15:8], 8'h5E);
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | STP);
        wait_idle("R7 idle");
        chk("R7 one stop", stops, t0 + 1);

        // fast mode
        min_hi = 1000;
        wr(A_CMD, 16'h0100 | {9'h0, SLV});
        wait_irq("R12 fast addr");
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | STP);
        wait_idle("R12 fast idle");
        chk("R12 fast high phase", min_hi, 2);

        // SCL held low by another device
        wr(A_CMD, {9'h0, SLV});
        wait_irq("R13 addr");
        wr(A_ISR, 16'h7);
        force_scl = 1'b1;
        wr(A_CTRL, EN | RDY);
        wait_irq("R13 timeout irq");
        rdr(A_ISR, v);  chk("R13 isr timeout", v, 16'h4);
        rdr(A_STAT, v); chk("R13 idle", v[0], 1'b0);
        chk("R13 lines released", {scl_pull, sda_pull}, 2'b00);
        force_scl = 1'b0;
        wr(A_ISR, 16'h7);
        repeat (20) @(negedge clk);

        // enable cleared mid-transfer, then command held while disabled
        wr(A_CMD, {9'h0, SLV});
        wait_irq("R14 addr");
        wr(A_ISR, 16'h7);
        wr(A_CTRL, 16'h0);
        chk("R14 lines released", {scl_pull, sda_pull}, 2'b00);
        rdr(A_STAT, v); chk("R14 idle", v[0], 1'b0);
        s0 = starts;
        wr(A_CMD, {9'h0, SLV});
        repeat (50) @(negedge clk);
        rdr(A_STAT, v); chk("R14 no start while disabled", v[0], 1'b0);
        chk("R14 no start seen", starts, s0);
        wr(A_CTRL, EN);
        wait_irq("R14 start after enable");
        chk("R14 start counted", starts, s0 + 1);
        wr(A_ISR, 16'h7);
        wr(A_CTRL, EN | RDY | STP);
        wait_idle("R14 final idle");

        finish_up();
    end
endmodule